// File: doc/BRIEF.md
# Control Chain Steering Stage

This block sits between the steps of a step-by-step control sequence and decides what starts next. An incoming advance strobe, active low and one clock wide, passes through a hold gate. The gate keeps the strobe back while an asynchronous wait input or a maintenance-halt input is asserted. Once released, the strobe is steered to one or both of two step outputs according to two branch conditions. A released strobe that finds neither condition true is lost, and this sets a sticky error flag.

Two further sections share the block. The rendezvous section collects the replies of several parallel chains. It issues a single joined advance once every chain has answered. The call section starts a called routine and holds its advance until that routine reports completion.

All strobes are synchronous to `clk_i`. The branch conditions must be stable in the cycle the released strobe appears. They must not come from the step whose strobe they steer.

Top module: `chain_steer`

## Requirements
- R1: Out of reset, `step_a_no`, `step_b_no`, `join_no` and `ret_no` are high, and `lost_o` and `call_go_o` are low.
- R2: When `adv_ni` is sampled low at an edge with `wait_i` and `halt_i` both low, the strobe is released in the following cycle for exactly one cycle.
- R3: In the release cycle, `step_a_no` is low exactly when `cond_a_i` is high, and `step_b_no` is low exactly when `cond_b_i` is high. Both may go low together. In every other cycle both outputs stay high.
- R4: A strobe sampled while `wait_i` is high stays pending. It is released in the cycle after the first edge at which `wait_i` and `halt_i` are both low. Several strobes that arrive while pending merge into one release.
- R5: `halt_i` holds a pending strobe exactly as `wait_i` does.
- R6: A release cycle in which both branch conditions are low sets `lost_o` at the next edge, and `lost_o` stays set.
- R7: `clr_i` sampled high clears `lost_o` at that edge. When a lost strobe occurs in the same cycle, the clear wins.
- R8: Each bit of `reply_i` is latched at the edge where it is sampled high. `join_no` is low for one cycle, in the cycle after the edge that latches the last missing reply. The edge that ends that cycle empties the latches, except for replies sampled high in that cycle, which count toward the next round.
- R9: A chain that replies more than once before the others counts once, so it cannot complete the join alone.
- R10: `call_ni` sampled low while idle raises `call_go_o` from the next cycle. `call_go_o` stays high until `ret_i` is sampled high. `ret_no` is then low for one cycle, in the cycle after that edge.
- R11: `ret_i` while no routine is active has no effect. `call_ni` while a routine is active is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| adv_ni | input | 1 | Incoming advance strobe, active low |
| wait_i | input | 1 | Wait condition, holds the advance while high |
| halt_i | input | 1 | Maintenance halt, holds the advance while high |
| cond_a_i | input | 1 | Branch condition for step A |
| cond_b_i | input | 1 | Branch condition for step B |
| clr_i | input | 1 | Synchronous clear of the lost-strobe flag |
| step_a_no | output | 1 | Advance strobe to step A, active low |
| step_b_no | output | 1 | Advance strobe to step B, active low |
| lost_o | output | 1 | Sticky lost-strobe error flag |
| reply_i | input | NCHAIN | Per-chain reply pulses |
| join_no | output | 1 | Joined advance strobe, active low |
| call_ni | input | 1 | Calling strobe, active low |
| ret_i | input | 1 | Completion reply from the called routine |
| call_go_o | output | 1 | Routine running, high while the call is outstanding |
| ret_no | output | 1 | Advance after routine completion, active low |

## Verification
The bench drives strobes into a closed gate and repeats them while the gate stays closed. A design without a pending latch would drop them, and one without merging would release twice. It fires lost strobes in the same cycle as a clear, where a wrong priority leaves the flag set. It lets one chain reply twice, which a counter-based join would mistake for completion. It sends fresh replies in the join cycle, which a design that wipes its latches unconditionally would lose. Stray returns and repeated calls target a call section that would otherwise emit spurious advances or restart a running routine.

// File: rtl/steer_pkg.sv
package steer_pkg;
  typedef struct packed {
    logic a;
    logic b;
  } br_cond_t;
endpackage

// File: rtl/steer_hold.sv
module steer_hold (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic adv_ni,
  input  logic wait_i,
  input  logic halt_i,
  output logic rel_o
);
  logic pend_q, rel_q;
  logic req, open, go;

  assign req  = pend_q | ~adv_ni;
  assign open = ~wait_i & ~halt_i;
  assign go   = req & open;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      rel_q  <= 1'b0;
    end else begin
      pend_q <= req & ~go;
      rel_q  <= go;
    end
  end

  assign rel_o = rel_q;

  // R4
  wait_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wait_i |=> !rel_o);
  // R5
  halt_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_i |=> !rel_o);
  // R2
  strobe_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adv_ni && !wait_i && !halt_i) |=> rel_o);
endmodule

// File: rtl/steer_branch.sv
module steer_branch
  import steer_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     rel_i,
  input  br_cond_t cond_i,
  input  logic     clr_i,
  output logic     step_a_no,
  output logic     step_b_no,
  output logic     lost_o
);
  logic lost_q;
  logic miss;

  assign step_a_no = ~(rel_i & cond_i.a);
  assign step_b_no = ~(rel_i & cond_i.b);
  assign miss      = rel_i & ~cond_i.a & ~cond_i.b;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    lost_q <= 1'b0;
    else if (clr_i) lost_q <= 1'b0;
    else if (miss)  lost_q <= 1'b1;
  end

  assign lost_o = lost_q;

  // R6
  lost_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_a_no && step_b_no && rel_i && !clr_i) |=> lost_o);
  // R7
  lost_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !lost_o);
  // R6
  lost_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lost_o && !clr_i) |=> lost_o);
endmodule

// File: rtl/steer_join.sv
module steer_join #(
  parameter int unsigned NCHAIN = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NCHAIN-1:0] reply_i,
  output logic              join_no
);
  logic [NCHAIN-1:0] seen_q;
  logic              full;

  assign full = &seen_q;

  for (genvar g = 0; g < NCHAIN; g++) begin : g_seen
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   seen_q[g] <= 1'b0;
      else if (full) seen_q[g] <= reply_i[g];
      else           seen_q[g] <= seen_q[g] | reply_i[g];
    end
  end

  assign join_no = ~full;

  // R8
  join_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !join_no |=> (seen_q == $past(reply_i)));
  // R9
  join_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !join_no |=> (join_no || $past(&reply_i)));
endmodule

// File: rtl/steer_call.sv
module steer_call (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic call_ni,
  input  logic ret_i,
  output logic call_go_o,
  output logic ret_no
);
  logic busy_q, done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= busy_q & ret_i;
      if (busy_q) busy_q <= ~ret_i;
      else        busy_q <= ~call_ni;
    end
  end

  assign call_go_o = busy_q;
  assign ret_no    = ~done_q;

  // R10
  call_ret_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (call_go_o && ret_i) |=> (!ret_no && !call_go_o));
  // R11
  stray_ret_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !call_go_o |=> ret_no);
endmodule

// File: rtl/chain_steer.sv
module chain_steer
  import steer_pkg::*;
#(
  parameter int unsigned NCHAIN = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adv_ni,
  input  logic              wait_i,
  input  logic              halt_i,
  input  logic              cond_a_i,
  input  logic              cond_b_i,
  input  logic              clr_i,
  output logic              step_a_no,
  output logic              step_b_no,
  output logic              lost_o,
  input  logic [NCHAIN-1:0] reply_i,
  output logic              join_no,
  input  logic              call_ni,
  input  logic              ret_i,
  output logic              call_go_o,
  output logic              ret_no
);
  logic     rel;
  br_cond_t cond;

  assign cond.a = cond_a_i;
  assign cond.b = cond_b_i;

  steer_hold i_hold (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .adv_ni(adv_ni),
    .wait_i(wait_i),
    .halt_i(halt_i),
    .rel_o (rel)
  );

  steer_branch i_branch (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rel_i    (rel),
    .cond_i   (cond),
    .clr_i    (clr_i),
    .step_a_no(step_a_no),
    .step_b_no(step_b_no),
    .lost_o   (lost_o)
  );

  steer_join #(.NCHAIN(NCHAIN)) i_join (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .reply_i(reply_i),
    .join_no(join_no)
  );

  steer_call i_call (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .call_ni  (call_ni),
    .ret_i    (ret_i),
    .call_go_o(call_go_o),
    .ret_no   (ret_no)
  );
endmodule

// File: tb/test_chain_steer.sv
module test_chain_steer;
  localparam int NCH = 3;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic adv_ni = 1'b1, wait_i = 1'b0, halt_i = 1'b0;
  logic cond_a_i = 1'b0, cond_b_i = 1'b0, clr_i = 1'b0;
  logic [NCH-1:0] reply_i = '0;
  logic call_ni = 1'b1, ret_i = 1'b0;
  logic step_a_no, step_b_no, lost_o, join_no, call_go_o, ret_no;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // reference state
  bit m_pend, m_rel, m_lost, m_busy, m_done;
  bit [NCH-1:0] m_seen;

  always #2 clk = ~clk;

  chain_steer #(.NCHAIN(NCH)) i_chain_steer (
    .clk_i(clk), .rst_ni(rst_ni), .adv_ni(adv_ni), .wait_i(wait_i),
    .halt_i(halt_i), .cond_a_i(cond_a_i), .cond_b_i(cond_b_i), .clr_i(clr_i),
    .step_a_no(step_a_no), .step_b_no(step_b_no), .lost_o(lost_o),
    .reply_i(reply_i), .join_no(join_no), .call_ni(call_ni), .ret_i(ret_i),
    .call_go_o(call_go_o), .ret_no(ret_no)
  );

  task automatic chk(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // advance the reference across the edge that has just passed
  task automatic model_edge();
    bit req, go, full;
    req  = m_pend | ~adv_ni;
    go   = req & ~wait_i & ~halt_i;
    if (clr_i) m_lost = 0;
    else if (m_rel && !cond_a_i && !cond_b_i) m_lost = 1;
    m_pend = req & ~go;
    m_rel  = go;
    full   = &m_seen;
    m_seen = full ? reply_i : (m_seen | reply_i);
    m_done = m_busy & ret_i;
    m_busy = m_busy ? ~ret_i : ~call_ni;
  endtask

  task automatic check_all();
    chk("R3 step_a", step_a_no, ~(m_rel & cond_a_i));
    chk("R3 step_b", step_b_no, ~(m_rel & cond_b_i));
    chk("R6/R7 lost", lost_o, m_lost);
    chk("R8/R9 join", join_no, ~(&m_seen));
    chk("R10/R11 call_go", call_go_o, m_busy);
    chk("R10/R11 ret", ret_no, ~m_done);
  endtask

  // one cycle: wait for edge, update reference, check, then drive next inputs
  task automatic step(bit adv, bit wt, bit ht, bit ca, bit cb, bit cl,
                      bit [NCH-1:0] rp, bit cal, bit rt);
    @(negedge clk);
    model_edge();
    check_all();
    adv_ni = adv; wait_i = wt; halt_i = ht; cond_a_i = ca; cond_b_i = cb;
    clr_i = cl; reply_i = rp; call_ni = cal; ret_i = rt;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(1,0,0,0,0,0,'0,1,0);
  endtask

  initial begin
    for (int c = 0; c < 200000; c++) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    m_pend = 0; m_rel = 0; m_lost = 0; m_busy = 0; m_done = 0; m_seen = '0;
    #1;
    // R1: reset state
    chk("R1 step_a", step_a_no, 1'b1);
    chk("R1 step_b", step_b_no, 1'b1);
    chk("R1 lost", lost_o, 1'b0);
    chk("R1 join", join_no, 1'b1);
    chk("R1 call_go", call_go_o, 1'b0);
    chk("R1 ret", ret_no, 1'b1);
    @(negedge clk); @(negedge clk);
    rst_ni = 1'b1;
    idle(2);

    // R2/R3: plain strobe, both branches taken
    step(0,0,0,1,1,0,'0,1,0);
    step(1,0,0,1,1,0,'0,1,0);
    chk("R2 step_a", step_a_no, 1'b0);
    chk("R3 step_b", step_b_no, 1'b0);
    idle(2);

    // R4: strobes during wait merge, released after wait drops
    step(0,1,0,1,0,0,'0,1,0);
    step(0,1,0,1,0,0,'0,1,0);
    step(1,1,0,1,0,0,'0,1,0);
    chk("R4 held", step_a_no, 1'b1);
    step(1,0,0,1,0,0,'0,1,0);
    step(1,0,0,1,0,0,'0,1,0);
    chk("R4 released", step_a_no, 1'b0);
    step(1,0,0,1,0,0,'0,1,0);
    chk("R4 single release", step_a_no, 1'b1);

    // R5: halt holds the same way
    step(0,0,1,0,1,0,'0,1,0);
    step(1,0,1,0,1,0,'0,1,0);
    chk("R5 halt holds", step_b_no, 1'b1);
    step(1,0,0,0,1,0,'0,1,0);
    step(1,0,0,0,1,0,'0,1,0);
    chk("R5 halt release", step_b_no, 1'b0);
    idle(1);

    // R6: lost strobe, R7: clear wins over simultaneous loss
    step(0,0,0,0,0,0,'0,1,0);
    step(1,0,0,0,0,0,'0,1,0);
    step(1,0,0,0,0,0,'0,1,0);
    chk("R6 lost set", lost_o, 1'b1);
    idle(3);
    chk("R6 lost sticky", lost_o, 1'b1);
    step(0,0,0,0,0,0,'0,1,0);
    step(1,0,0,0,0,1,'0,1,0);
    step(1,0,0,0,0,0,'0,1,0);
    chk("R7 clear wins", lost_o, 1'b0);

    // R9: chain 0 replies twice, no join; R8: order 0,2,1 then new reply in join cycle
    step(1,0,0,0,0,0,3'b001,1,0);
    step(1,0,0,0,0,0,3'b001,1,0);
    step(1,0,0,0,0,0,3'b100,1,0);
    step(1,0,0,0,0,0,3'b000,1,0);
    chk("R9 no early join", join_no, 1'b1);
    step(1,0,0,0,0,0,3'b010,1,0);
    step(1,0,0,0,0,0,3'b110,1,0);
    chk("R8 join pulse", join_no, 1'b0);
    step(1,0,0,0,0,0,3'b001,1,0);
    chk("R8 join one cycle", join_no, 1'b1);
    idle(1);
    chk("R8 kept replies join", join_no, 1'b0);
    idle(2);

    // R11: stray return, R10: call then return, R11: recall while busy
    step(1,0,0,0,0,0,'0,1,1);
    step(1,0,0,0,0,0,'0,0,0);
    chk("R11 stray ret", ret_no, 1'b1);
    step(1,0,0,0,0,0,'0,0,0);
    chk("R10 call_go", call_go_o, 1'b1);
    step(1,0,0,0,0,0,'0,1,1);
    step(1,0,0,0,0,0,'0,1,0);
    chk("R10 ret pulse", ret_no, 1'b0);
    chk("R10 call_go drop", call_go_o, 1'b0);
    idle(2);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      step(($urandom % 4) != 0, ($urandom % 3) == 0, ($urandom % 8) == 0,
           $urandom % 2, $urandom % 2, ($urandom % 16) == 0,
           {($urandom % 4) == 0, ($urandom % 4) == 0, ($urandom % 4) == 0},
           ($urandom % 6) != 0, ($urandom % 4) == 0);
    end
    idle(3);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule